// File: doc/BRIEF.md
# Two-Stage Prescaled Edge-Point PWM Generator

This block drives one fan-control pulse-width-modulated pin. The system clock first passes through a prescaler with two stages in series. The first stage divides by a power of two. The second stage divides by an even count, or passes every tick through when its code is zero. Each prescaled tick steps an 8-bit period counter. The counter wraps once it reaches the programmed period unit, so one output period lasts unit plus one ticks.

The duty cycle comes from two absolute counter positions: a rise point and a fall point. There is no single compare threshold. The pin goes high when the counter reaches the rise point and goes low when it reaches the fall point. A rise point and a fall point that are both zero request a pin that stays high. A cleared enable forces the pin low and parks the counter and the prescaler.

The configuration inputs are captured into shadow registers at a period boundary, or at any time while the port is disabled. Software can therefore change them at any moment without producing a truncated pulse. The prescaler gives a one-cycle tick enable, so the whole block runs in a single clock domain.

Top module: `pwmgen_top`

## Requirements
- R1: The high divider code H (input `div_hi_code`) makes the prescaler divide the clock by 2^H.
- R2: The low divider code L (input `div_lo_code`) adds a further divide by 1 when L is 0 and by 2·L otherwise. The tick rate is clk / (2^H · lowdiv).
- R3: One output period lasts `period_unit` + 1 prescaled ticks, so the pin frequency is clk / (2^H · lowdiv · (unit + 1)).
- R4: The pin is driven high when the counter equals the rise point and low when it equals the fall point. At all other counter values it keeps its level. The pin lags the counter by one clock cycle.
- R5: When the rise point and the fall point are both 0, the pin stays high for the whole period (100% duty).
- R6: While `port_en` is 0 the pin is low on the following cycle and stays low (0% duty).
- R7: Each prescaled tick advances the counter by one. The tick that arrives while the counter equals the period unit returns it to 0. Without a tick the counter holds.
- R8: New divider codes, period unit, rise point and fall point are captured only at the tick that wraps the counter, or whenever the port is disabled. Changes made during an enabled period have no effect until that boundary.
- R9: After reset, and whenever the port is disabled, the counter and prescaler are cleared and the pin is low.
- R10: When the rise point equals a nonzero fall point, the fall takes precedence and the pin stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; 0 forces the pin low and parks the counter |
| div_hi_code | input | HI_W (3) | Power-of-two divider exponent H |
| div_lo_code | input | LO_W (4) | Even divider code L (0 means divide by 1) |
| period_unit | input | CNT_W (8) | Last counter value of a period |
| rise_pt | input | CNT_W (8) | Counter value at which the pin rises |
| fall_pt | input | CNT_W (8) | Counter value at which the pin falls |
| pwm_out | output | 1 | PWM pin |

## Verification
The checker assumes the configuration inputs are steady around the clock edge and that the parameters are set so that the largest period, 2^H · 2L · 256 cycles, fits the counter widths. It does not assume that the inputs are held for a whole period. The stimulus drives every input on the falling edge. It draws random codes with small H, L and unit, so that many period boundaries occur in a short run. It rewrites the configuration at arbitrary points inside a period, so the capture at the boundary is exercised constantly. Directed phases then pin down exact duty counts for full-on, equal-point, disabled and each divider stage.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;
   localparam int unsigned PWMGEN_CNT_W_DEF = 8;
   localparam int unsigned PWMGEN_HI_W_DEF  = 3;
   localparam int unsigned PWMGEN_LO_W_DEF  = 4;

   // what the edge stage does with the pin in a given cycle
   typedef enum logic [1:0] {
      LV_HOLD  = 2'd0,
      LV_SET   = 2'd1,
      LV_CLR   = 2'd2,
      LV_FORCE = 2'd3
   } pwmgen_act_e;
endpackage

// File: rtl/pwmgen_prescaler.sv
module pwmgen_prescaler #(
   parameter int unsigned HI_W         = 3,
   parameter int unsigned LO_W         = 4,
   parameter bit          HAS_HI_STAGE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [HI_W-1:0] hi_code,
   input  logic [LO_W-1:0] lo_code,
   output logic            tick
);
   localparam int unsigned POW_W = (1 << HI_W) - 1;
   localparam int unsigned LD_W  = LO_W + 1;

   logic            pow_tick;
   logic [LD_W-1:0] lo_div;
   logic [LD_W-1:0] lo_cnt;

   generate
      if (HAS_HI_STAGE) begin : g_hi
         localparam logic [POW_W-1:0] ONES = {POW_W{1'b1}};
         logic [POW_W-1:0] pow_cnt;
         logic [POW_W-1:0] pow_mask;

         assign pow_mask = ONES >> (POW_W - 32'(hi_code));
         assign pow_tick = ((pow_cnt & pow_mask) == pow_mask);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          pow_cnt <= '0;
            else if (!run)       pow_cnt <= '0;
            else if (tick)       pow_cnt <= '0;
            else                 pow_cnt <= pow_cnt + 1'b1;
         end
      end else begin : g_no_hi
         assign pow_tick = 1'b1;
      end
   endgenerate

   assign lo_div = (lo_code == '0) ? LD_W'(1) : {lo_code, 1'b0};
   assign tick   = run && pow_tick && (lo_cnt == lo_div - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lo_cnt <= '0;
      else if (!run)      lo_cnt <= '0;
      else if (tick)      lo_cnt <= '0;
      else if (pow_tick)  lo_cnt <= lo_cnt + 1'b1;
   end
endmodule

// File: rtl/pwmgen_period.sv
module pwmgen_period #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] unit,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   logic at_end;

   assign at_end = (cnt == unit);
   assign wrap   = tick && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!run)    cnt <= '0;
      else if (tick)    cnt <= at_end ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/pwmgen_shadow.sv
module pwmgen_shadow #(
   parameter int unsigned HI_W  = 3,
   parameter int unsigned LO_W  = 4,
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [HI_W-1:0]  hi_in,
   input  logic [LO_W-1:0]  lo_in,
   input  logic [CNT_W-1:0] unit_in,
   input  logic [CNT_W-1:0] rise_in,
   input  logic [CNT_W-1:0] fall_in,
   output logic [HI_W-1:0]  hi_q,
   output logic [LO_W-1:0]  lo_q,
   output logic [CNT_W-1:0] unit_q,
   output logic [CNT_W-1:0] rise_q,
   output logic [CNT_W-1:0] fall_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q   <= '0;
         lo_q   <= '0;
         unit_q <= '0;
         rise_q <= '0;
         fall_q <= '0;
      end else if (load) begin
         hi_q   <= hi_in;
         lo_q   <= lo_in;
         unit_q <= unit_in;
         rise_q <= rise_in;
         fall_q <= fall_in;
      end
   end
endmodule

// File: rtl/pwmgen_edge.sv
module pwmgen_edge
   import pwmgen_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] rise,
   input  logic [CNT_W-1:0] fall,
   output logic             pin
);
   pwmgen_act_e act;
   logic        lvl_nxt;

   always_comb begin
      if (rise == '0 && fall == '0) act = LV_FORCE;
      else if (cnt == fall)         act = LV_CLR;
      else if (cnt == rise)         act = LV_SET;
      else                          act = LV_HOLD;
   end

   always_comb begin
      unique case (act)
         LV_FORCE, LV_SET: lvl_nxt = 1'b1;
         LV_CLR:           lvl_nxt = 1'b0;
         default:          lvl_nxt = pin;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin <= 1'b0;
      else        pin <= run && lvl_nxt;
   end
endmodule

// File: rtl/pwmgen_top.sv
module pwmgen_top
   import pwmgen_pkg::*;
#(
   parameter int unsigned HI_W         = PWMGEN_HI_W_DEF,
   parameter int unsigned LO_W         = PWMGEN_LO_W_DEF,
   parameter int unsigned CNT_W        = PWMGEN_CNT_W_DEF,
   parameter bit          HAS_HI_STAGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             port_en,
   input  logic [HI_W-1:0]  div_hi_code,
   input  logic [LO_W-1:0]  div_lo_code,
   input  logic [CNT_W-1:0] period_unit,
   input  logic [CNT_W-1:0] rise_pt,
   input  logic [CNT_W-1:0] fall_pt,
   output logic             pwm_out
);
   generate
      if (HI_W < 1 || HI_W > 4) begin : g_bad_hi
         $error("pwmgen_top: HI_W must lie in 1..4");
      end
      if (LO_W < 1 || LO_W > 8) begin : g_bad_lo
         $error("pwmgen_top: LO_W must lie in 1..8");
      end
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("pwmgen_top: CNT_W must lie in 2..16");
      end
   endgenerate

   logic             tick;
   logic             wrap;
   logic             cfg_load;
   logic [CNT_W-1:0] cnt_q;
   logic [HI_W-1:0]  hi_s;
   logic [LO_W-1:0]  lo_s;
   logic [CNT_W-1:0] unit_s;
   logic [CNT_W-1:0] rise_s;
   logic [CNT_W-1:0] fall_s;

   assign cfg_load = !port_en || wrap;

   pwmgen_shadow #(.HI_W(HI_W), .LO_W(LO_W), .CNT_W(CNT_W)) u_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cfg_load),
      .hi_in   (div_hi_code),
      .lo_in   (div_lo_code),
      .unit_in (period_unit),
      .rise_in (rise_pt),
      .fall_in (fall_pt),
      .hi_q    (hi_s),
      .lo_q    (lo_s),
      .unit_q  (unit_s),
      .rise_q  (rise_s),
      .fall_q  (fall_s)
   );

   pwmgen_prescaler #(.HI_W(HI_W), .LO_W(LO_W), .HAS_HI_STAGE(HAS_HI_STAGE)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (port_en),
      .hi_code (hi_s),
      .lo_code (lo_s),
      .tick    (tick)
   );

   pwmgen_period #(.CNT_W(CNT_W)) u_period (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (port_en),
      .tick  (tick),
      .unit  (unit_s),
      .cnt   (cnt_q),
      .wrap  (wrap)
   );

   pwmgen_edge #(.CNT_W(CNT_W)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (port_en),
      .cnt   (cnt_q),
      .rise  (rise_s),
      .fall  (fall_s),
      .pin   (pwm_out)
   );
endmodule

// File: rtl/pwmgen_checks.sv
module pwmgen_checks #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             port_en,
   input logic             pwm_out,
   input logic             tick,
   input logic             wrap,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] rise_s,
   input logic [CNT_W-1:0] fall_s,
   input logic [CNT_W-1:0] unit_s
);
   a_r6_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |=> !pwm_out);

   a_r9_off_parked: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |=> (cnt == '0));

   a_r5_full_on: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && rise_s == '0 && fall_s == '0) |=> pwm_out);

   a_r4_fall_point: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && !(rise_s == '0 && fall_s == '0) && cnt == fall_s) |=> !pwm_out);

   a_r4_rise_point: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && cnt == rise_s && cnt != fall_s) |=> pwm_out);

   a_r10_equal_points: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && rise_s == fall_s && rise_s != '0 && cnt == rise_s) |=> !pwm_out);

   a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && wrap) |=> (cnt == '0));

   a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && tick && cnt != unit_s) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && !tick) |=> $stable(cnt));

   a_r8_cfg_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && !wrap) |=> ($stable(rise_s) && $stable(fall_s) && $stable(unit_s)));
endmodule

bind pwmgen_top pwmgen_checks #(.CNT_W(CNT_W)) u_checks (
   .clk     (clk),
   .rst_n   (rst_n),
   .port_en (port_en),
   .pwm_out (pwm_out),
   .tick    (tick),
   .wrap    (wrap),
   .cnt     (cnt_q),
   .rise_s  (rise_s),
   .fall_s  (fall_s),
   .unit_s  (unit_s)
);

// File: tb/pwmgen_top_test.sv
module pwmgen_top_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       port_en = 1'b0;
   logic [2:0] div_hi_code = '0;
   logic [3:0] div_lo_code = '0;
   logic [7:0] period_unit = '0;
   logic [7:0] rise_pt = '0;
   logic [7:0] fall_pt = '0;
   logic       pwm_out;

   always #5 clk = ~clk;

   pwmgen_top uut (
      .clk(clk), .rst_n(rst_n), .port_en(port_en),
      .div_hi_code(div_hi_code), .div_lo_code(div_lo_code),
      .period_unit(period_unit), .rise_pt(rise_pt), .fall_pt(fall_pt),
      .pwm_out(pwm_out)
   );

   int    n_tests = 0;
   int    n_fail  = 0;
   string cur_req = "R4";
   bit    cmp_on  = 1'b0;
   bit    done    = 1'b0;

   task automatic chk(bit ok, string req, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // reference model built from the requirements
   int         m_pre;
   logic [7:0] m_cnt;
   logic       m_out;
   logic [2:0] s_h;
   logic [3:0] s_l;
   logic [7:0] s_u, s_r, s_f;

   function automatic int total_div(logic [2:0] h, logic [3:0] l);
      return (1 << h) * ((l == 0) ? 1 : 2 * int'(l));
   endfunction

   function automatic logic want_lvl(logic [7:0] c, logic [7:0] r, logic [7:0] f, logic prev);
      if (r == 0 && f == 0) return 1'b1;
      if (c == f)           return 1'b0;
      if (c == r)           return 1'b1;
      return prev;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pre <= 0; m_cnt <= '0; m_out <= 1'b0;
         s_h <= '0; s_l <= '0; s_u <= '0; s_r <= '0; s_f <= '0;
      end else if (!port_en) begin
         m_pre <= 0; m_cnt <= '0; m_out <= 1'b0;
         s_h <= div_hi_code; s_l <= div_lo_code; s_u <= period_unit;
         s_r <= rise_pt; s_f <= fall_pt;
      end else begin
         m_out <= want_lvl(m_cnt, s_r, s_f, m_out);
         if (m_pre == total_div(s_h, s_l) - 1) begin
            m_pre <= 0;
            if (m_cnt == s_u) begin
               m_cnt <= '0;
               s_h <= div_hi_code; s_l <= div_lo_code; s_u <= period_unit;
               s_r <= rise_pt; s_f <= fall_pt;
            end else begin
               m_cnt <= m_cnt + 1'b1;
            end
         end else begin
            m_pre <= m_pre + 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && cmp_on && !done)
         chk(pwm_out === m_out, cur_req, int'(pwm_out), int'(m_out));
   end

   task automatic set_cfg(int h, int l, int u, int r, int f);
      @(negedge clk);
      div_hi_code = 3'(h); div_lo_code = 4'(l);
      period_unit = 8'(u); rise_pt = 8'(r); fall_pt = 8'(f);
   endtask

   task automatic high_count(int n, output int hi);
      hi = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         hi += int'(pwm_out);
      end
   endtask

   // restart the port so that a new configuration is captured at once
   task automatic restart(int h, int l, int u, int r, int f);
      set_cfg(h, l, u, r, f);
      port_en = 1'b0;
      @(negedge clk);
      port_en = 1'b1;
      repeat (200) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int hi;
      void'($urandom(32'h1234_5eed));

      // R9: pin low while reset is held
      repeat (3) @(negedge clk);
      chk(pwm_out == 1'b0, "R9", int'(pwm_out), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(pwm_out == 1'b0, "R9", int'(pwm_out), 0);
      cmp_on = 1'b1;

      // R1: divide by 2 from H=1; unit 3 -> 8 cycles, high at counts 1..2 -> 4 cycles
      restart(1, 0, 3, 1, 3);
      high_count(80, hi);
      chk(hi == 40, "R1", hi, 40);

      // R2: L=2 -> divide by 4; unit 4 -> 20 cycles, high at count 0 only -> 4 cycles
      restart(0, 2, 4, 0, 1);
      high_count(100, hi);
      chk(hi == 20, "R2", hi, 20);

      // R3/R4: undivided, unit 9 -> 10 cycles, high for counts 0..4
      restart(0, 0, 9, 0, 5);
      high_count(100, hi);
      chk(hi == 50, "R3", hi, 50);

      // R4: wrapped window, rise 7 fall 2 -> high for counts 7,8,9,0,1
      restart(0, 0, 9, 7, 2);
      high_count(100, hi);
      chk(hi == 50, "R4", hi, 50);

      // R5: both points zero -> always high
      restart(0, 1, 5, 0, 0);
      high_count(100, hi);
      chk(hi == 100, "R5", hi, 100);

      // R10: equal nonzero points -> always low
      restart(0, 0, 7, 3, 3);
      high_count(64, hi);
      chk(hi == 0, "R10", hi, 0);

      // R6: disabled port with a full-on setting stays low
      set_cfg(0, 0, 5, 0, 0);
      port_en = 1'b0;
      high_count(50, hi);
      chk(hi == 0, "R6", hi, 0);

      // R8: mid-period rewrite; the reference model defers it to the boundary
      cur_req = "R8";
      restart(0, 0, 19, 0, 10);
      repeat (7) @(negedge clk);
      fall_pt = 8'd2;
      repeat (3) @(negedge clk);
      rise_pt = 8'd15;
      repeat (60) @(negedge clk);

      // R7/R8: random configurations changed at arbitrary points
      cur_req = "R7";
      for (int k = 0; k < 60; k++) begin
         int u;
         u = int'($urandom_range(0, 15));
         set_cfg(int'($urandom_range(0, 2)), int'($urandom_range(0, 3)), u,
                 int'($urandom_range(0, u + 2)), int'($urandom_range(0, u + 2)));
         port_en = ($urandom_range(0, 9) != 0);
         repeat (int'($urandom_range(20, 300))) @(negedge clk);
      end

      // R9: reset in the middle of activity clears the pin
      cmp_on = 1'b0;
      set_cfg(0, 0, 3, 0, 0);
      port_en = 1'b1;
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(pwm_out == 1'b0, "R9", int'(pwm_out), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule